// File: doc/BRIEF.md
# Indexed DMA Channel Programming Interface

This block is the register front end of a multi-channel DMA controller. Software reaches every channel through only two byte-wide locations on a simple host bus. A write to the function port picks an operation and a channel. Later accesses to the execute port carry that operation's operands, one byte per access. An internal byte pointer tracks how many operand bytes have been moved.

Each channel holds five settings: a 24-bit memory address, a 16-bit transfer count stored as transfers minus one, a 16-bit I/O port address, a mode byte and an enable bit. The block drives all of these to the transfer engine in parallel. It also decodes the mode bits into separate direction, target and width flags. The transfer engine reports finished channels on `tc_done`. Software can read those terminal-count flags back and clear them. A single global arbitration byte and a master clear complete the set of operations.

Top module: `dma_chan_prog`

## Requirements
- R1: After reset, every bit of `chan_enable` is 0, and all address, count, I/O, mode and arbitration outputs are 0. The function port reads back 0xD0, the status byte reads 0, and execute accesses have no effect until a function write is made.
- R2: A function-port write of 0xA0|c (unmask) sets `chan_enable[c]`, and 0x90|c (mask) clears it. Either change is visible in the cycle after the write, with no execute access. The channel number c is taken from the low log2(NCH) bits of the written byte.
- R3: After a function write of 0x20|c, three execute writes load address bits 7:0, then 15:8, then 23:16. The result appears on `mem_addr_o[24c+23:24c]`. Configuration outputs change only on bus writes.
- R4: After a function write of 0x30|c, three execute reads return address bytes 7:0, 15:8 and 23:16, in that order. Each byte appears on `bus_rdata` in the cycle after its read strobe.
- R5: After a function write of 0x40|c, two execute writes (low byte, then high byte) load `count_o[16c+15:16c]`. Software writes the number of transfers minus one. After a function write of 0x50|c, two execute reads return that stored value, low byte first.
- R6: After a function write of 0x00|c, two execute writes (low byte, then high byte) load `io_addr_o[16c+15:16c]`.
- R7: After a function write of 0x70|c, one execute write loads `mode_o[8c+7:8c]`. The decoded flags follow the mode bits: `xfer_on[c]` = bit 2, `to_mem[c]` = bit 2 AND bit 3, `io_target[c]` = bit 0, and `wide16[c]` = bit 6.
- R8: After a function write of 0x80 (channel bits ignored), one execute write loads `arb_level_o`.
- R9: A rising `tc_done[c]` pulse sets status flag c. After a function write of 0x60, the first execute read returns the flags with channel c at bit c, and that read clears them. A pulse in the same cycle as the clearing read stays set.
- R10: Every function write resets the byte pointer. Operand lengths are 3 bytes for 0x20 and 0x30, 2 bytes for 0x00, 0x40 and 0x50, 1 byte for 0x60, 0x70 and 0x80, and 0 for all other codes. Execute writes beyond the operand length are ignored, and execute reads beyond it return 0.
- R11: A function write of 0xD0 masks every channel. It also clears all address, count, I/O, mode, arbitration and status state, in the cycle after the write.
- R12: Accesses to bus addresses other than 0x18 (function) and 0x1A (execute) are ignored. Such reads return 0, and `bus_rdata` is 0 in any cycle that does not follow a read. A read of the function port returns the last function byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte (a write in the same cycle wins) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after `bus_rd` |
| tc_done | input | NCH | Terminal-count pulses from the transfer engine |
| chan_enable | output | NCH | Per-channel enable (1 = unmasked) |
| mem_addr_o | output | NCH*24 | Memory addresses, channel c at bits 24c+23:24c |
| count_o | output | NCH*16 | Stored counts (transfers minus one) |
| io_addr_o | output | NCH*16 | I/O port addresses |
| mode_o | output | NCH*8 | Raw mode bytes |
| xfer_on | output | NCH | Mode bit 2 per channel |
| to_mem | output | NCH | Transfer into memory (mode bits 2 and 3 both set) |
| io_target | output | NCH | I/O-port target (mode bit 0) |
| wide16 | output | NCH | 16-bit transfers (mode bit 6) |
| arb_level_o | output | 8 | Arbitration byte |

## Verification
A wrong byte pointer shows up at once: the next execute write lands in the wrong byte of a channel output, or the next readback byte comes back shifted or zero, one cycle after the access. A wrong channel decode puts a value on the wrong slice of the flattened outputs or flips the wrong `chan_enable` bit on the edge of the function write. Status-flag faults stay hidden until the next status read, where a flag is either missing or has failed to clear. The bench therefore reads status back twice, and once with a terminal-count pulse aligned to the clearing read.

// File: rtl/dma_prog_pkg.sv
package dma_prog_pkg;

  localparam int MEM_AW = 24;
  localparam int CNT_W  = 16;
  localparam int IOA_W  = 16;
  localparam int MODE_W = 8;

  localparam int MEM_NB = MEM_AW / 8;
  localparam int CNT_NB = CNT_W / 8;
  localparam int IOA_NB = IOA_W / 8;
  localparam int PTR_W  = 2;

  localparam logic [3:0] OP_SET_IO   = 4'h0;
  localparam logic [3:0] OP_SET_ADDR = 4'h2;
  localparam logic [3:0] OP_GET_ADDR = 4'h3;
  localparam logic [3:0] OP_SET_CNT  = 4'h4;
  localparam logic [3:0] OP_GET_CNT  = 4'h5;
  localparam logic [3:0] OP_GET_STAT = 4'h6;
  localparam logic [3:0] OP_SET_MODE = 4'h7;
  localparam logic [3:0] OP_SET_ARB  = 4'h8;
  localparam logic [3:0] OP_MASK     = 4'h9;
  localparam logic [3:0] OP_UNMASK   = 4'hA;
  localparam logic [3:0] OP_CLEAR    = 4'hD;

  localparam logic [7:0] FN_IDLE = 8'hD0;

  localparam int MB_IO    = 0;
  localparam int MB_XFER  = 2;
  localparam int MB_TOMEM = 3;
  localparam int MB_WIDE  = 6;

  function automatic logic [PTR_W-1:0] op_len(input logic [3:0] op);
    case (op)
      OP_SET_ADDR, OP_GET_ADDR:            op_len = PTR_W'(MEM_NB);
      OP_SET_CNT, OP_GET_CNT:              op_len = PTR_W'(CNT_NB);
      OP_SET_IO:                           op_len = PTR_W'(IOA_NB);
      OP_GET_STAT, OP_SET_MODE, OP_SET_ARB: op_len = PTR_W'(1);
      default:                             op_len = '0;
    endcase
  endfunction

endpackage

// File: rtl/dma_fn_seq.sv
module dma_fn_seq
  import dma_prog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fn_we,
  input  logic [7:0]       fn_wdata,
  input  logic             ex_acc,
  output logic [7:0]       fn_q,
  output logic [PTR_W-1:0] ptr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fn_q  <= FN_IDLE;
      ptr_q <= '0;
    end else if (fn_we) begin
      fn_q  <= fn_wdata;
      ptr_q <= '0;
    end else if (ex_acc && (ptr_q != '1)) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_prog_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              we,
  input  logic [3:0]        op,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [7:0]        wdata,
  output logic              en_q,
  output logic [MEM_AW-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [IOA_W-1:0]  io_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              xfer_on,
  output logic              to_mem,
  output logic              io_target,
  output logic              wide16
);

  always_ff @(posedge clk) begin
    if (clr) begin
      en_q   <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      io_q   <= '0;
      mode_q <= '0;
    end else begin
      if (en_set)      en_q <= 1'b1;
      else if (en_clr) en_q <= 1'b0;
      if (we) begin
        case (op)
          OP_SET_ADDR:
            for (int b = 0; b < MEM_NB; b++)
              if (ptr == PTR_W'(b)) addr_q[8*b +: 8] <= wdata;
          OP_SET_CNT:
            for (int b = 0; b < CNT_NB; b++)
              if (ptr == PTR_W'(b)) cnt_q[8*b +: 8] <= wdata;
          OP_SET_IO:
            for (int b = 0; b < IOA_NB; b++)
              if (ptr == PTR_W'(b)) io_q[8*b +: 8] <= wdata;
          OP_SET_MODE:
            mode_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign xfer_on   = mode_q[MB_XFER];
  assign to_mem    = mode_q[MB_XFER] & mode_q[MB_TOMEM];
  assign io_target = mode_q[MB_IO];
  assign wide16    = mode_q[MB_WIDE];

endmodule

// File: rtl/dma_tc_status.sv
module dma_tc_status #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tc_in_valid_clr,
  input  logic           rd_clr,
  input  logic [NCH-1:0] tc_in,
  output logic [7:0]     stat_byte
);

  logic [NCH-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst || tc_in_valid_clr) flags_q <= '0;
    else                        flags_q <= (rd_clr ? '0 : flags_q) | tc_in;
  end

  generate
    if (NCH >= 8) begin : g_wide
      assign stat_byte = flags_q[7:0];
    end else begin : g_narrow
      assign stat_byte = {{(8-NCH){1'b0}}, flags_q};
    end
  endgenerate

endmodule

// File: rtl/dma_chan_prog.sv
module dma_chan_prog
  import dma_prog_pkg::*;
#(
  parameter int                NCH     = 8,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] FN_OFF  = 8'h18,
  parameter logic [ADDR_W-1:0] EXE_OFF = 8'h1A
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  input  logic [NCH-1:0]        tc_done,
  output logic [NCH-1:0]        chan_enable,
  output logic [NCH*MEM_AW-1:0] mem_addr_o,
  output logic [NCH*CNT_W-1:0]  count_o,
  output logic [NCH*IOA_W-1:0]  io_addr_o,
  output logic [NCH*MODE_W-1:0] mode_o,
  output logic [NCH-1:0]        xfer_on,
  output logic [NCH-1:0]        to_mem,
  output logic [NCH-1:0]        io_target,
  output logic [NCH-1:0]        wide16,
  output logic [7:0]            arb_level_o
);

  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic             fn_we, ex_we, fn_re, ex_re, mclr;
  logic [3:0]       new_op, cur_op;
  logic [CH_W-1:0]  new_ch, cur_ch;
  logic             new_ok, cur_ok, in_len, ex_live_wr, stat_clr;
  logic [7:0]       fn_q, stat_byte, ex_val;
  logic [PTR_W-1:0] ptr_q;

  logic [MEM_AW-1:0] addr_arr [NCH];
  logic [CNT_W-1:0]  cnt_arr  [NCH];

  assign fn_we  = bus_wr && (bus_addr == FN_OFF);
  assign ex_we  = bus_wr && (bus_addr == EXE_OFF);
  assign fn_re  = bus_rd && !bus_wr && (bus_addr == FN_OFF);
  assign ex_re  = bus_rd && !bus_wr && (bus_addr == EXE_OFF);

  assign new_op = bus_wdata[7:4];
  assign new_ch = bus_wdata[CH_W-1:0];
  assign new_ok = int'(new_ch) < NCH;
  assign mclr   = fn_we && (new_op == OP_CLEAR);

  dma_fn_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .fn_we    (fn_we),
    .fn_wdata (bus_wdata),
    .ex_acc   (ex_we || ex_re),
    .fn_q     (fn_q),
    .ptr_q    (ptr_q)
  );

  assign cur_op     = fn_q[7:4];
  assign cur_ch     = fn_q[CH_W-1:0];
  assign cur_ok     = int'(cur_ch) < NCH;
  assign in_len     = ptr_q < op_len(cur_op);
  assign ex_live_wr = ex_we && in_len;
  assign stat_clr   = ex_re && in_len && (cur_op == OP_GET_STAT);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [CH_W-1:0] CID = CH_W'(c);
    logic [IOA_W-1:0]  io_w;
    logic [MODE_W-1:0] mode_w;

    dma_chan_regs u_regs (
      .clk       (clk),
      .clr       (rst || mclr),
      .en_set    (fn_we && new_ok && (new_op == OP_UNMASK) && (new_ch == CID)),
      .en_clr    (fn_we && new_ok && (new_op == OP_MASK) && (new_ch == CID)),
      .we        (ex_live_wr && cur_ok && (cur_ch == CID)),
      .op        (cur_op),
      .ptr       (ptr_q),
      .wdata     (bus_wdata),
      .en_q      (chan_enable[c]),
      .addr_q    (addr_arr[c]),
      .cnt_q     (cnt_arr[c]),
      .io_q      (io_w),
      .mode_q    (mode_w),
      .xfer_on   (xfer_on[c]),
      .to_mem    (to_mem[c]),
      .io_target (io_target[c]),
      .wide16    (wide16[c])
    );

    assign mem_addr_o[c*MEM_AW +: MEM_AW] = addr_arr[c];
    assign count_o[c*CNT_W +: CNT_W]      = cnt_arr[c];
    assign io_addr_o[c*IOA_W +: IOA_W]    = io_w;
    assign mode_o[c*MODE_W +: MODE_W]     = mode_w;
  end

  dma_tc_status #(.NCH(NCH)) u_stat (
    .clk             (clk),
    .rst             (rst),
    .tc_in_valid_clr (mclr),
    .rd_clr          (stat_clr),
    .tc_in           (tc_done),
    .stat_byte       (stat_byte)
  );

  always_ff @(posedge clk) begin
    if (rst || mclr)                             arb_level_o <= '0;
    else if (ex_live_wr && cur_op == OP_SET_ARB) arb_level_o <= bus_wdata;
  end

  always_comb begin
    ex_val = '0;
    if (in_len) begin
      case (cur_op)
        OP_GET_ADDR:
          if (cur_ok)
            for (int b = 0; b < MEM_NB; b++)
              if (ptr_q == PTR_W'(b)) ex_val = addr_arr[cur_ch][8*b +: 8];
        OP_GET_CNT:
          if (cur_ok)
            for (int b = 0; b < CNT_NB; b++)
              if (ptr_q == PTR_W'(b)) ex_val = cnt_arr[cur_ch][8*b +: 8];
        OP_GET_STAT:
          ex_val = stat_byte;
        default: ex_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (fn_re) bus_rdata <= fn_q;
    else if (ex_re) bus_rdata <= ex_val;
    else            bus_rdata <= '0;
  end

endmodule

// File: rtl/dma_chan_prog_chk.sv
module dma_chan_prog_chk #(
  parameter int                NCH     = 8,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] FN_OFF  = 8'h18,
  parameter logic [ADDR_W-1:0] EXE_OFF = 8'h1A
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [7:0]          bus_wdata,
  input logic [7:0]          bus_rdata,
  input logic [NCH-1:0]      chan_enable,
  input logic [NCH*24-1:0]   mem_addr_o
);

  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [CH_W-1:0] last_ch;
  logic            fn_wr;

  assign fn_wr = bus_wr && (bus_addr == FN_OFF);

  always_ff @(posedge clk) last_ch <= bus_wdata[CH_W-1:0];

  // R1
  reset_masked_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (chan_enable == '0 && mem_addr_o == '0));

  // R2
  mask_applies_chk: assert property (@(posedge clk) disable iff (rst)
    (fn_wr && bus_wdata[7:4] == 4'h9 && int'(bus_wdata[CH_W-1:0]) < NCH)
    |=> !chan_enable[last_ch]);

  // R2
  unmask_applies_chk: assert property (@(posedge clk) disable iff (rst)
    (fn_wr && bus_wdata[7:4] == 4'hA && int'(bus_wdata[CH_W-1:0]) < NCH)
    |=> chan_enable[last_ch]);

  // R11
  master_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (fn_wr && bus_wdata == 8'hD0) |=> (chan_enable == '0 && mem_addr_o == '0));

  // R10
  exe_keeps_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == EXE_OFF) |=> $stable(chan_enable));

  // R3
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |=> $stable(mem_addr_o));

  // R12
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && !bus_wr) |=> (bus_rdata == 8'h00));

endmodule

bind dma_chan_prog dma_chan_prog_chk #(
  .NCH(NCH), .ADDR_W(ADDR_W), .FN_OFF(FN_OFF), .EXE_OFF(EXE_OFF)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .chan_enable (chan_enable),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/dma_chan_prog_bench.sv
module dma_chan_prog_bench;

  localparam int NCH = 8;
  localparam logic [7:0] FN = 8'h18;
  localparam logic [7:0] EX = 8'h1A;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rst = 1'b1;
  logic [7:0]          bus_addr = '0;
  logic                bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]          bus_wdata = '0;
  logic [7:0]          bus_rdata;
  logic [NCH-1:0]      tc_done = '0;
  logic [NCH-1:0]      chan_enable, xfer_on, to_mem, io_target, wide16;
  logic [NCH*24-1:0]   mem_addr_o;
  logic [NCH*16-1:0]   count_o, io_addr_o;
  logic [NCH*8-1:0]    mode_o;
  logic [7:0]          arb_level_o;

  dma_chan_prog u_dma_chan_prog (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tc_done(tc_done),
    .chan_enable(chan_enable), .mem_addr_o(mem_addr_o), .count_o(count_o),
    .io_addr_o(io_addr_o), .mode_o(mode_o), .xfer_on(xfer_on), .to_mem(to_mem),
    .io_target(io_target), .wide16(wide16), .arb_level_o(arb_level_o)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;

  task automatic chk(string tag, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic acc(bit wr, bit rd, logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic fn_w(logic [7:0] d); acc(1, 0, FN, d); endtask
  task automatic ex_w(logic [7:0] d); acc(1, 0, EX, d); endtask

  // driver: push the expected byte, then issue the read
  task automatic rd_exp(logic [7:0] a, logic [7:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    acc(0, 1, a, 8'h00);
  endtask

  task automatic tc_pulse(logic [NCH-1:0] v);
    @(negedge clk); tc_done = v;
    @(posedge clk); #1; tc_done = '0;
  endtask

  // monitor: compare each read result against the scoreboard queue
  always @(posedge clk) pend <= bus_rd && !bus_wr && !rst;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk("R1 enable", chan_enable, 0);
    chk("R1 addr", mem_addr_o, 0);
    chk("R1 arb", arb_level_o, 0);
    rd_exp(FN, 8'hD0, "R1 fn readback");
    ex_w(8'h77);
    chk("R1 exe ignored", io_addr_o, 0);

    // R2 mask / unmask
    fn_w(8'hA3);
    chk("R2 unmask 3", chan_enable, 8'h08);
    fn_w(8'hA5);
    fn_w(8'h93);
    chk("R2 mask 3", chan_enable, 8'h20);

    // R10 execute write under zero-length op
    ex_w(8'hFF);
    chk("R10 zero-length op", chan_enable, 8'h20);
    chk("R10 zero-length addr", mem_addr_o, 0);

    // R3 set memory address on channel 2
    fn_w(8'h22); ex_w(8'h56); ex_w(8'h34); ex_w(8'h12);
    chk("R3 addr ch2", mem_addr_o[2*24 +: 24], 24'h123456);
    ex_w(8'h99);
    chk("R10 overrun write", mem_addr_o[2*24 +: 24], 24'h123456);

    // R4 get memory address
    fn_w(8'h32);
    rd_exp(EX, 8'h56, "R4 byte0");
    rd_exp(EX, 8'h34, "R4 byte1");
    rd_exp(EX, 8'h12, "R4 byte2");
    rd_exp(EX, 8'h00, "R10 overrun read");

    // R5 set / get count (0x1000 transfers stored as 0x0FFF)
    fn_w(8'h41); ex_w(8'hFF); ex_w(8'h0F);
    chk("R5 count ch1", count_o[1*16 +: 16], 16'h0FFF);
    fn_w(8'h51);
    rd_exp(EX, 8'hFF, "R5 count low");
    rd_exp(EX, 8'h0F, "R5 count high");

    // R6 I/O address on channel 7
    fn_w(8'h07); ex_w(8'hEF); ex_w(8'hBE);
    chk("R6 io ch7", io_addr_o[7*16 +: 16], 16'hBEEF);

    // R7 mode decode on channel 4
    fn_w(8'h74); ex_w(8'h4C);
    chk("R7 mode ch4", mode_o[4*8 +: 8], 8'h4C);
    chk("R7 decode 4C", {xfer_on[4], to_mem[4], io_target[4], wide16[4]}, 4'b1101);
    fn_w(8'h74); ex_w(8'h05);
    chk("R7 decode 05", {xfer_on[4], to_mem[4], io_target[4], wide16[4]}, 4'b1010);

    // R8 arbitration
    fn_w(8'h80); ex_w(8'h0B);
    chk("R8 arb", arb_level_o, 8'h0B);

    // R9 status flags
    tc_pulse(8'h42);
    fn_w(8'h60);
    rd_exp(EX, 8'h42, "R9 status");
    rd_exp(EX, 8'h00, "R10 status overrun");
    fn_w(8'h60);
    exp_q.push_back(8'h00); tag_q.push_back("R9 cleared");
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = EX; tc_done = 8'h04;
    @(posedge clk); #1;
    bus_rd = 1'b0; tc_done = '0;
    fn_w(8'h60);
    rd_exp(EX, 8'h04, "R9 coincident pulse kept");

    // R10 pointer restarts on every function write
    fn_w(8'h22); ex_w(8'hAA);
    fn_w(8'h22); ex_w(8'hBB); ex_w(8'hCC); ex_w(8'hDD);
    chk("R10 pointer reset", mem_addr_o[2*24 +: 24], 24'hDDCCBB);

    // R12 other addresses
    acc(1, 0, 8'h19, 8'hA0);
    chk("R12 stray write", chan_enable, 8'h20);
    rd_exp(8'h00, 8'h00, "R12 stray read");
    rd_exp(FN, 8'h22, "R12 fn readback");

    // R11 master clear
    fn_w(8'hA0);
    tc_pulse(8'h01);
    fn_w(8'hD0);
    chk("R11 enable", chan_enable, 0);
    chk("R11 addr", mem_addr_o, 0);
    chk("R11 count", count_o, 0);
    chk("R11 io", io_addr_o, 0);
    chk("R11 mode", mode_o, 0);
    chk("R11 arb", arb_level_o, 0);
    fn_w(8'h60);
    rd_exp(EX, 8'h00, "R11 status");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule